// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and a byte-wide asynchronous static RAM of 2M words. The host issues single-beat requests through a valid/ready handshake. Each request carries a write flag, a 21-bit address and a write byte. The controller then produces the RAM pin sequence. It has a chip-select pair of opposite polarity, an active-low write strobe and an active-low read enable, and it splits the shared data bus into a drive value, a drive enable and a sampled input. A read returns its byte on a one-cycle response strobe.

All waiting is done by counting clock cycles. The RAM's limits are given to the block as nanosecond parameters, along with the clock period. Elaboration rounds each limit up to whole cycles, so the same block covers both speed grades (55 ns or 70 ns cycle). A turnaround timer holds back a write that follows a read until the RAM's outputs have floated. Because of this, the host and the memory never drive the bus together. Reads are not held back by this timer.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, req_ready is 1 (with req_write low), mem_csel_n is 1, mem_csel is 0, mem_wstb_n is 1, mem_rden_n is 1, mem_drive is 0 and rsp_valid is 0.
- R2: Both chip selects are asserted (mem_csel_n = 0, mem_csel = 1) whenever the read enable or the write strobe is low. Both are deasserted in the cycle a read result is presented and after the write hold cycle ends.
- R3: A read holds mem_rden_n low, with mem_wstb_n high and mem_addr unchanged, for exactly RD_CYC cycles. RD_CYC is the larger of ceil(access time / clock) and ceil(enable-to-data time / clock), which is 6 at the defaults (10 ns clock, fast grade).
- R4: rsp_rdata carries the byte present on mem_rdata at the last clock edge of the read window. rsp_valid is high for exactly one cycle, in the cycle after the edge that lies RD_CYC edges after the accepting edge.
- R5: A write holds mem_wstb_n low for exactly WP_CYC = ceil(max(pulse, data setup) / clock) cycles, which is 6 at the defaults. mem_drive and mem_wdata are held from the strobe fall until one cycle after the strobe rises, so mem_drive is high for WP_CYC+1 cycles. The bus is then released.
- R6: mem_drive is never high while mem_rden_n is low.
- R7: A write that follows a read starts driving no earlier than FLT_CYC = ceil(max(enable float, deselect float) / clock) cycles after mem_rden_n rises, which is 3 at the defaults. When the write is already waiting, the gap is exactly FLT_CYC, and the acceptances are RD_CYC+FLT_CYC cycles apart.
- R8: A read that waits behind another read is accepted in the cycle its predecessor's result appears, so the two acceptances are RD_CYC+1 cycles apart.
- R9: req_ready is low throughout an access. A request that is held while the block is busy is accepted exactly once, and no response appears without a read. The full address range works, up to 0x1FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | 8 | Byte read from memory |
| mem_addr | output | 21 | Address pins to the RAM |
| mem_csel_n | output | 1 | Active-low chip select |
| mem_csel | output | 1 | Active-high chip select |
| mem_wstb_n | output | 1 | Active-low write strobe |
| mem_rden_n | output | 1 | Active-low output (read) enable |
| mem_wdata | output | 8 | Value driven onto the data bus |
| mem_drive | output | 1 | Bus drive enable for mem_wdata |
| mem_rdata | input | 8 | Value sampled from the data bus |

## Verification
A cycle counter or sequencer state that is off by one shows up at the pins as a read-enable or write-strobe window that is one cycle too short or too long. It also moves the response strobe by a cycle. Both are visible on the first access that follows. A turnaround timer that is wrong appears on the first write issued straight after a read: either the drive enable rises while the read enable is still low, or the acceptance spacing differs from RD_CYC+FLT_CYC. A capture on the wrong edge or a stale data register appears as a byte mismatch on the next read-back. This applies in particular to an overwritten address and to the top address.

// File: rtl/sac_pkg.sv
package sac_pkg;

   typedef enum logic [1:0] {
      SAC_IDLE   = 2'd0,
      SAC_READ   = 2'd1,
      SAC_WPULSE = 2'd2,
      SAC_WHOLD  = 2'd3
   } sac_state_e;

   // round a nanosecond limit up to whole clock periods
   function automatic int ns2cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sac_cycle_timer.sv
module sac_cycle_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sac_seq.sv
module sac_seq
   import sac_pkg::*;
#(
   parameter int CNT_W   = 3,
   parameter int FLT_W   = 2,
   parameter int RD_CYC  = 6,
   parameter int WP_CYC  = 6,
   parameter int FLT_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             acc_zero,
   input  logic             flt_zero,
   output logic             req_ready,
   output logic             acc_load,
   output logic [CNT_W-1:0] acc_val,
   output logic             acc_dec,
   output logic             flt_load,
   output logic [FLT_W-1:0] flt_val,
   output logic             start_rd,
   output logic             start_wr,
   output logic             end_rd,
   output logic             end_wp,
   output logic             end_hold
);

   localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CYC - 1);
   localparam logic [FLT_W-1:0] FLT_LOAD = FLT_W'(FLT_CYC - 1);

   sac_state_e state_q, state_d;
   logic       fire;

   // writes wait for the read turnaround, reads never do
   assign req_ready = (state_q == SAC_IDLE) && (!req_write || flt_zero);
   assign fire      = req_valid && req_ready;
   assign flt_val   = FLT_LOAD;

   always_comb begin
      state_d  = state_q;
      acc_load = 1'b0;
      acc_val  = RD_LOAD;
      acc_dec  = 1'b0;
      flt_load = 1'b0;
      start_rd = 1'b0;
      start_wr = 1'b0;
      end_rd   = 1'b0;
      end_wp   = 1'b0;
      end_hold = 1'b0;
      unique case (state_q)
         SAC_IDLE: begin
            if (fire) begin
               acc_load = 1'b1;
               if (req_write) begin
                  acc_val  = WP_LOAD;
                  start_wr = 1'b1;
                  state_d  = SAC_WPULSE;
               end else begin
                  acc_val  = RD_LOAD;
                  start_rd = 1'b1;
                  state_d  = SAC_READ;
               end
            end
         end
         SAC_READ: begin
            if (acc_zero) begin
               end_rd   = 1'b1;
               flt_load = 1'b1;
               state_d  = SAC_IDLE;
            end else begin
               acc_dec = 1'b1;
            end
         end
         SAC_WPULSE: begin
            if (acc_zero) begin
               end_wp  = 1'b1;
               state_d = SAC_WHOLD;
            end else begin
               acc_dec = 1'b1;
            end
         end
         SAC_WHOLD: begin
            end_hold = 1'b1;
            state_d  = SAC_IDLE;
         end
         default: state_d = SAC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SAC_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/sac_pin_drv.sv
module sac_pin_drv #(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_rd,
   input  logic              start_wr,
   input  logic              end_rd,
   input  logic              end_wp,
   input  logic              end_hold,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [DATA_W-1:0] bus_in,
   output logic [ADDR_W-1:0] pin_addr,
   output logic              pin_sel,
   output logic              pin_wstb_n,
   output logic              pin_rden_n,
   output logic [DATA_W-1:0] pin_wdata,
   output logic              pin_drive,
   output logic [DATA_W-1:0] cap_data,
   output logic              cap_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_addr   <= '0;
         pin_sel    <= 1'b0;
         pin_wstb_n <= 1'b1;
         pin_rden_n <= 1'b1;
         pin_wdata  <= '0;
         pin_drive  <= 1'b0;
         cap_data   <= '0;
         cap_valid  <= 1'b0;
      end else begin
         cap_valid <= 1'b0;
         if (start_rd) begin
            pin_addr   <= addr_in;
            pin_sel    <= 1'b1;
            pin_rden_n <= 1'b0;
         end
         if (start_wr) begin
            pin_addr   <= addr_in;
            pin_wdata  <= wdata_in;
            pin_sel    <= 1'b1;
            pin_wstb_n <= 1'b0;
            pin_drive  <= 1'b1;
         end
         if (end_rd) begin
            // sampled while the read enable is still low
            cap_data   <= bus_in;
            cap_valid  <= 1'b1;
            pin_rden_n <= 1'b1;
            pin_sel    <= 1'b0;
         end
         if (end_wp) begin
            pin_wstb_n <= 1'b1;
         end
         if (end_hold) begin
            pin_drive <= 1'b0;
            pin_sel   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sac_pkg::*;
#(
   parameter int ADDR_W    = 21,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 10,
   parameter int T_ACC_NS  = 55,
   parameter int T_OEV_NS  = 30,
   parameter int T_OFLT_NS = 25,
   parameter int T_DFLT_NS = 30,
   parameter int T_WP_NS   = 55,
   parameter int T_DS_NS   = 55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_csel_n,
   output logic              mem_csel,
   output logic              mem_wstb_n,
   output logic              mem_rden_n,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_drive,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int RD_CYC  = imax(1, imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OEV_NS, CLK_NS)));
   localparam int WP_CYC  = imax(1, ns2cyc(imax(T_WP_NS, T_DS_NS), CLK_NS));
   localparam int FLT_CYC = imax(1, ns2cyc(imax(T_OFLT_NS, T_DFLT_NS), CLK_NS));
   localparam int CNT_W   = $clog2(imax(RD_CYC, WP_CYC) + 1);
   localparam int FLT_W   = $clog2(FLT_CYC + 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_async_ctrl: CLK_NS must be positive");
   end
   if ((ADDR_W < 1) || (DATA_W < 1)) begin : g_bad_width
      $error("sram_async_ctrl: widths must be positive");
   end
   if ((T_ACC_NS < 0) || (T_OEV_NS < 0) || (T_OFLT_NS < 0) || (T_DFLT_NS < 0) ||
       (T_WP_NS < 0) || (T_DS_NS < 0)) begin : g_bad_time
      $error("sram_async_ctrl: timing limits must not be negative");
   end

   logic             acc_load, acc_dec, acc_zero;
   logic [CNT_W-1:0] acc_val;
   logic             flt_load, flt_zero;
   logic [FLT_W-1:0] flt_val;
   logic             start_rd, start_wr, end_rd, end_wp, end_hold;
   logic             sel;

   sac_seq #(
      .CNT_W   (CNT_W),
      .FLT_W   (FLT_W),
      .RD_CYC  (RD_CYC),
      .WP_CYC  (WP_CYC),
      .FLT_CYC (FLT_CYC)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .acc_zero  (acc_zero),
      .flt_zero  (flt_zero),
      .req_ready (req_ready),
      .acc_load  (acc_load),
      .acc_val   (acc_val),
      .acc_dec   (acc_dec),
      .flt_load  (flt_load),
      .flt_val   (flt_val),
      .start_rd  (start_rd),
      .start_wr  (start_wr),
      .end_rd    (end_rd),
      .end_wp    (end_wp),
      .end_hold  (end_hold)
   );

   sac_cycle_timer #(.W(CNT_W)) i_acc_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acc_load),
      .load_val (acc_val),
      .dec      (acc_dec),
      .zero     (acc_zero)
   );

   // a single-cycle float window is already covered by the idle cycle
   if (FLT_CYC > 1) begin : g_flt_timer
      sac_cycle_timer #(.W(FLT_W)) i_flt_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (flt_load),
         .load_val (flt_val),
         .dec      (1'b1),
         .zero     (flt_zero)
      );
   end else begin : g_flt_none
      logic unused_flt;
      assign unused_flt = flt_load ^ (^flt_val);
      assign flt_zero   = 1'b1;
   end

   sac_pin_drv #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_rd   (start_rd),
      .start_wr   (start_wr),
      .end_rd     (end_rd),
      .end_wp     (end_wp),
      .end_hold   (end_hold),
      .addr_in    (req_addr),
      .wdata_in   (req_wdata),
      .bus_in     (mem_rdata),
      .pin_addr   (mem_addr),
      .pin_sel    (sel),
      .pin_wstb_n (mem_wstb_n),
      .pin_rden_n (mem_rden_n),
      .pin_wdata  (mem_wdata),
      .pin_drive  (mem_drive),
      .cap_data   (rsp_rdata),
      .cap_valid  (rsp_valid)
   );

   assign mem_csel_n = ~sel;
   assign mem_csel   = sel;

endmodule

// File: rtl/sac_checker.sv
module sac_checker
   import sac_pkg::*;
#(
   parameter int ADDR_W  = 21,
   parameter int RD_CYC  = 6,
   parameter int WP_CYC  = 6,
   parameter int FLT_CYC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_csel_n,
   input logic              mem_csel,
   input logic              mem_wstb_n,
   input logic              mem_rden_n,
   input logic              mem_drive
);

   localparam int RW = $clog2(imax(imax(RD_CYC, WP_CYC), FLT_CYC) + 2) + 1;
   localparam logic [RW-1:0] SAT = '1;

   logic [RW-1:0] rd_run, wp_run, gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_run <= '0;
         wp_run <= '0;
         gap    <= SAT;
      end else begin
         rd_run <= !mem_rden_n ? ((rd_run == SAT) ? SAT : rd_run + 1'b1) : '0;
         wp_run <= !mem_wstb_n ? ((wp_run == SAT) ? SAT : wp_run + 1'b1) : '0;
         gap    <= !mem_rden_n ? '0 : ((gap == SAT) ? SAT : gap + 1'b1);
      end
   end

   p_sel_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rden_n |-> (!mem_csel_n && mem_csel && mem_wstb_n));
   p_sel_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wstb_n |-> (!mem_csel_n && mem_csel && mem_drive));
   p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_csel_n && !mem_csel));
   p_read_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rden_n) |-> (rd_run == RW'(RD_CYC)));
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rden_n && $past(!mem_rden_n)) |-> $stable(mem_addr));
   p_rsp_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rden_n) |-> rsp_valid);
   p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   p_wp_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wstb_n) |-> (wp_run == RW'(WP_CYC)));
   p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wstb_n) |-> mem_drive);
   p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_drive && !mem_rden_n));
   p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_drive) |-> (gap >= RW'(FLT_CYC)));
   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rden_n || !mem_wstb_n) |-> !req_ready);

endmodule

bind sram_async_ctrl sac_checker #(
   .ADDR_W  (ADDR_W),
   .RD_CYC  (RD_CYC),
   .WP_CYC  (WP_CYC),
   .FLT_CYC (FLT_CYC)
) i_sac_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_addr   (mem_addr),
   .mem_csel_n (mem_csel_n),
   .mem_csel   (mem_csel),
   .mem_wstb_n (mem_wstb_n),
   .mem_rden_n (mem_rden_n),
   .mem_drive  (mem_drive)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

   localparam int CLK_NS = 10;
   localparam int RD  = (55 + CLK_NS - 1) / CLK_NS;  // access dominates enable-to-data
   localparam int WP  = (55 + CLK_NS - 1) / CLK_NS;
   localparam int FLT = (30 + CLK_NS - 1) / CLK_NS;  // deselect float dominates

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [20:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [20:0] mem_addr;
   logic        mem_csel_n, mem_csel, mem_wstb_n, mem_rden_n, mem_drive;
   logic [7:0]  mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   sram_async_ctrl i_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_csel_n(mem_csel_n), .mem_csel(mem_csel), .mem_wstb_n(mem_wstb_n),
      .mem_rden_n(mem_rden_n), .mem_wdata(mem_wdata), .mem_drive(mem_drive),
      .mem_rdata(mem_rdata)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0] ram    [int];
   logic [7:0] shadow [int];

   function automatic logic [7:0] init_byte(input logic [20:0] a);
      return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'hA5;
   endfunction

   function automatic logic [7:0] model_rd(input logic [20:0] a);
      if (ram.exists(int'(a))) return ram[int'(a)];
      return init_byte(a);
   endfunction

   function automatic logic [7:0] exp_byte(input logic [20:0] a);
      if (shadow.exists(int'(a))) return shadow[int'(a)];
      return init_byte(a);
   endfunction

   always_comb begin
      if (!mem_csel_n && mem_csel && !mem_rden_n && mem_wstb_n) mem_rdata = model_rd(mem_addr);
      else mem_rdata = 8'h00;
   end

   always @(posedge mem_wstb_n) begin
      if (!mem_csel_n && mem_csel && mem_drive) ram[int'(mem_addr)] = mem_wdata;
   end

   // ---------------- scoreboard ----------------
   typedef struct { logic [7:0] d; int c; } exp_t;
   exp_t q[$];

   task automatic do_req(input logic wr, input logic [20:0] a, input logic [7:0] d,
                         output int acc_c);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
      acc_c = cyc;
      if (wr) shadow[int'(a)] = d;
      else q.push_back('{exp_byte(a), acc_c + RD});
      req_valid = 1'b0;
   endtask

   // ---------------- monitor ----------------
   logic prev_rden_n = 1'b1, prev_wstb_n = 1'b1, prev_drive = 1'b0, prev_rv = 1'b0;
   int   rd_run = 0, wp_run = 0, dr_run = 0, rden_rise_c = -100, last_gap = -1, n_rsp = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_rden_n) rd_run++;
         if (!mem_wstb_n) wp_run++;
         if (mem_drive) dr_run++;
         if (!mem_rden_n && prev_rden_n) begin
            chk(!mem_csel_n && mem_csel && mem_wstb_n, "R2", "select during read", {mem_csel_n, mem_csel}, 2'b01);
            chk(!req_ready, "R9", "ready during read", req_ready, 0);
         end
         if (mem_rden_n && !prev_rden_n) begin
            chk(rd_run == RD, "R3", "read window cycles", rd_run, RD);
            rd_run = 0;
            rden_rise_c = cyc;
         end
         if (!mem_wstb_n && prev_wstb_n) begin
            chk(!mem_csel_n && mem_csel && mem_drive, "R2", "select during write", {mem_csel_n, mem_csel}, 2'b01);
            chk(!req_ready, "R9", "ready during write", req_ready, 0);
         end
         if (mem_wstb_n && !prev_wstb_n) begin
            chk(wp_run == WP, "R5", "write strobe cycles", wp_run, WP);
            chk(mem_drive, "R5", "data held after strobe", mem_drive, 1);
            wp_run = 0;
         end
         if (mem_drive && !prev_drive) begin
            last_gap = cyc - rden_rise_c;
            chk(last_gap >= FLT, "R7", "float gap before drive", last_gap, FLT);
         end
         if (!mem_drive && prev_drive) begin
            chk(dr_run == WP + 1, "R5", "drive cycles", dr_run, WP + 1);
            chk(mem_csel_n && !mem_csel, "R2", "deselect after write", {mem_csel_n, mem_csel}, 2'b10);
            dr_run = 0;
         end
         if (mem_drive) chk(mem_rden_n, "R6", "drive with read enable low", mem_rden_n, 1);
         if (rsp_valid) begin
            n_rsp++;
            chk(!prev_rv, "R4", "response pulse width", prev_rv, 0);
            chk(mem_csel_n && !mem_csel && mem_rden_n, "R2", "deselect at response", {mem_csel_n, mem_csel}, 2'b10);
            if (q.size() == 0) begin
               chk(1'b0, "R9", "response without read", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(rsp_rdata == e.d, "R4", "read data", rsp_rdata, e.d);
               chk(cyc == e.c, "R4", "response cycle", cyc, e.c);
            end
         end
         prev_rden_n = mem_rden_n;
         prev_wstb_n = mem_wstb_n;
         prev_drive  = mem_drive;
         prev_rv     = rsp_valid;
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int c0, c1, c2, c3;
      int n_reads;
      n_reads = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(req_ready, "R1", "req_ready", req_ready, 1);
      chk(mem_csel_n, "R1", "mem_csel_n", mem_csel_n, 1);
      chk(!mem_csel, "R1", "mem_csel", mem_csel, 0);
      chk(mem_wstb_n, "R1", "mem_wstb_n", mem_wstb_n, 1);
      chk(mem_rden_n, "R1", "mem_rden_n", mem_rden_n, 1);
      chk(!mem_drive, "R1", "mem_drive", mem_drive, 0);
      chk(!rsp_valid, "R1", "rsp_valid", rsp_valid, 0);

      // writes at both ends of the range, then read back (R9 held requests)
      do_req(1'b1, 21'h000000, 8'h3C, c0);
      do_req(1'b1, 21'h1FFFFF, 8'hC3, c0);
      do_req(1'b0, 21'h000000, 8'h00, c1); n_reads++;
      do_req(1'b0, 21'h1FFFFF, 8'h00, c2); n_reads++;
      chk(c2 - c1 == RD + 1, "R8", "read-to-read acceptance spacing", c2 - c1, RD + 1);

      // write queued straight behind a read
      do_req(1'b1, 21'h012345, 8'hFF, c3);
      chk(c3 - c2 == RD + FLT, "R7", "read-to-write acceptance spacing", c3 - c2, RD + FLT);
      @(negedge clk);
      #1;
      chk(last_gap == FLT, "R7", "exact float gap", last_gap, FLT);

      do_req(1'b0, 21'h012345, 8'h00, c0); n_reads++;
      do_req(1'b0, 21'h0ABCDE, 8'h00, c0); n_reads++;   // never written
      do_req(1'b1, 21'h000001, 8'h00, c0);
      do_req(1'b1, 21'h000001, 8'hA5, c0);              // overwrite
      do_req(1'b0, 21'h000001, 8'h00, c0); n_reads++;
      do_req(1'b1, 21'h100000, 8'h5A, c0);
      do_req(1'b0, 21'h100000, 8'h00, c0); n_reads++;
      do_req(1'b0, 21'h1FFFFF, 8'h00, c0); n_reads++;

      repeat (RD + FLT + 6) @(negedge clk);
      #1;
      chk(q.size() == 0, "R9", "pending expected responses", q.size(), 0);
      chk(n_rsp == n_reads, "R9", "response count", n_rsp, n_reads);
      chk(req_ready && mem_csel_n && !mem_csel, "R2", "idle after traffic", {req_ready, mem_csel_n, mem_csel}, 3'b110);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule